// File: doc/BRIEF.md
# Multiplexed ADC serial command engine

This block is the two-wire bus slave that sits in front of a small 10-bit acquisition core with up to three analog channels. The master addresses it with one command byte. The upper nibble of that byte carries a fixed device type. The lower nibble chooses between a conversion and an access to the alarm-limit storage, names a channel (or asks for automatic channel stepping) and says whether data is to be read. Conversion results stream back as a two-byte pair: a header that echoes the channel, then the low byte. A new conversion is launched every time the master acknowledges a low byte. Limit registers can be written with two data bytes, which are committed on STOP, or read back as four bytes.

The converter sits outside the block and is reached through a one-cycle start pulse with a channel number, and a done strobe that returns 10 bits. The limit storage is internal. It is modelled as a register file whose write occupies a timed busy window. While that window is open, the block refuses its own address. SCL and SDA are synchronised to the system clock. SDA is driven only as an open-drain pull-down enable.

Top module: `adcs_cmd_engine`

## Requirements
- R1: After reset the SDA pull-down is released and no converter start is issued while the bus stays idle.
- R2: A command byte is acknowledged only when bits 7..4 equal 1001. Any other type is not acknowledged, and the block keeps SDA released until the next START.
- R3: A command with bit 3 = 0, bits 2..1 = channel c (c below the channel count) and bit 0 = 1 is acknowledged. It issues one converter start on channel c. The next byte read is {0000, c[1:0], D9, D8} and the one after it is D7..D0. A NACK followed by STOP issues no further start.
- R4: When the master ACKs a low result byte, one new conversion starts on the same channel, and the following two bytes carry that new result.
- R5: When bits 2..1 = 11 and bit 3 = 0, conversions start on channel 0 and step 0, 1, 2, 0 (wrapping after the last channel). Each header echoes the channel that was actually converted.
- R6: A limit write is the command with bit 3 = 1 and bit 0 = 0, then a header byte {0000, U, O, D9, D8} (U = 1 selects the upper limit, O is the option bit), then D7..D0. The 11-bit value {O, D9..D0} is stored only at STOP. A repeated START before STOP discards it.
- R7: A limit read (bit 3 = 1, bit 0 = 1) returns four bytes: {1, c[1:0], 0, 0, O, D9, D8}, then the lower low byte, then {1, c[1:0], 0, 1, O, D9, D8}, then the upper low byte. All limits read as zero after reset.
- R8: For WR_CYCLES system clocks after a committed limit write, the block does not acknowledge its own address. After that it acknowledges again.
- R9: The block does not acknowledge a command with bit 3 = 0 and bit 0 = 0 (monitor request), or a limit access with a channel at or above the channel count.
- R10: SDA drive changes only while the synchronised SCL is low, and the pull-down is off whenever the link is idle.
- R11: Each converter start is a single-cycle pulse whose channel number is below the channel count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | Pull SDA low when 1 |
| adc_start | output | 1 | One-cycle converter start |
| adc_chan | output | 2 | Channel to convert, valid with adc_start |
| adc_done | input | 1 | Converter result strobe |
| adc_data | input | 10 | Converter result, valid with adc_done |

## Verification
Each bus input passes through two synchroniser flops and one edge register. As a result, the ACK pull-down, every transmitted bit and each converter start appear three to four system clocks after the SCL edge that triggers them. The master model always samples SDA half a high period after a rising edge, so every result it checks has had a full low half-period of twenty clocks to settle. The converter model answers three clocks after a start. It is therefore valid long before the falling edge that loads the next header. The write-busy window is tested by addressing the block right after STOP, which lies well inside WR_CYCLES, and then again after waiting longer than WR_CYCLES.

// File: rtl/adcs_pkg.sv
package adcs_pkg;
  localparam logic [3:0] TYPE_ID = 4'b1001;
  localparam int DATA_W = 10;
  localparam int LIM_W  = DATA_W + 1;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_ACKA, S_RX, S_ACKW, S_TX, S_MACK, S_SKIP
  } link_st_t;

  typedef struct packed {
    logic [3:0] id;
    logic       lim;
    logic [1:0] ch;
    logic       rd;
  } cmd_byte_t;

  function automatic logic [7:0] conv_hdr(input logic [1:0] ch, input logic [DATA_W-1:0] d);
    return {4'b0000, ch, d[9:8]};
  endfunction

  function automatic logic [7:0] lim_hdr(input logic [1:0] ch, input logic up,
                                         input logic [LIM_W-1:0] r);
    return {1'b1, ch, 1'b0, up, r[10], r[9:8]};
  endfunction

  function automatic logic [1:0] next_ch(input logic [1:0] ch, input int nch);
    if (int'(ch) >= nch - 1) return 2'd0;
    return ch + 2'd1;
  endfunction

  function automatic logic cmd_valid(input logic [7:0] b, input int nch);
    cmd_byte_t c;
    c = cmd_byte_t'(b);
    if (c.id != TYPE_ID) return 1'b0;
    if (c.lim) return int'(c.ch) < nch;
    if (!c.rd) return 1'b0;
    return (c.ch == 2'b11) || (int'(c.ch) < nch);
  endfunction

  function automatic logic [7:0] sel_byte(input logic lim, input logic [1:0] idx,
                                          input logic [1:0] ch, input logic [DATA_W-1:0] adc,
                                          input logic [LIM_W-1:0] lo, input logic [LIM_W-1:0] hi);
    if (!lim) return idx[0] ? adc[7:0] : conv_hdr(ch, adc);
    case (idx)
      2'd0:    return lim_hdr(ch, 1'b0, lo);
      2'd1:    return lo[7:0];
      2'd2:    return lim_hdr(ch, 1'b1, hi);
      default: return hi[7:0];
    endcase
  endfunction
endpackage

// File: rtl/adcs_line_sync.sv
module adcs_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic ev_rise,
  output logic ev_fall,
  output logic ev_start,
  output logic ev_stop
);
  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[SYNC_STAGES-1];
      sda_d    <= sda_pipe[SYNC_STAGES-1];
    end
  end

  assign scl_s    = scl_pipe[SYNC_STAGES-1];
  assign sda_s    = sda_pipe[SYNC_STAGES-1];
  assign ev_rise  = scl_s & ~scl_d;
  assign ev_fall  = ~scl_s & scl_d;
  assign ev_start = scl_s & scl_d & sda_d & ~sda_s;
  assign ev_stop  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/adcs_limit_file.sv
module adcs_limit_file
  import adcs_pkg::*;
#(
  parameter int NCH       = 3,
  parameter int WR_CYCLES = 2000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_ch,
  input  logic             wr_upper,
  input  logic [LIM_W-1:0] wr_val,
  input  logic [1:0]       rd_ch,
  output logic [LIM_W-1:0] rd_lower,
  output logic [LIM_W-1:0] rd_upper,
  output logic             busy
);
  localparam int CW = $clog2(WR_CYCLES + 1);

  logic [LIM_W-1:0] lo_all [NCH];
  logic [LIM_W-1:0] hi_all [NCH];
  logic [CW-1:0]    wait_cnt;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [LIM_W-1:0] lo_r, hi_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_r <= '0;
        hi_r <= '0;
      end else if (wr_en && wr_ch == 2'(g)) begin
        if (wr_upper) hi_r <= wr_val;
        else          lo_r <= wr_val;
      end
    end
    assign lo_all[g] = lo_r;
    assign hi_all[g] = hi_r;
  end

  always_comb begin
    rd_lower = '0;
    rd_upper = '0;
    for (int i = 0; i < NCH; i++) begin
      if (rd_ch == 2'(i)) begin
        rd_lower = lo_all[i];
        rd_upper = hi_all[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 wait_cnt <= '0;
    else if (wr_en)             wait_cnt <= CW'(WR_CYCLES);
    else if (wait_cnt != '0)    wait_cnt <= wait_cnt - 1'b1;
  end

  assign busy = (wait_cnt != '0);
endmodule

// File: rtl/adcs_link.sv
module adcs_link
  import adcs_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              ev_rise,
  input  logic              ev_fall,
  input  logic              ev_start,
  input  logic              ev_stop,
  output logic              sda_oe,
  output logic              adc_start,
  output logic [1:0]        adc_chan,
  input  logic              adc_done,
  input  logic [DATA_W-1:0] adc_data,
  input  logic              busy,
  output logic              wr_commit,
  output logic [1:0]        wr_ch,
  output logic              wr_upper,
  output logic [LIM_W-1:0]  wr_val,
  input  logic [LIM_W-1:0]  rd_lower,
  input  logic [LIM_W-1:0]  rd_upper,
  output logic              addr_done,
  output logic              addr_ok,
  output logic              in_idle
);
  link_st_t          st;
  logic [3:0]        bitcnt;
  logic [7:0]        rx_sh, tx_sh, lo_byte;
  logic [3:0]        hdr_q;
  logic              cmd_lim, cmd_rd, cmd_auto;
  logic [1:0]        cmd_ch, cur_ch, byte_idx, wcnt;
  logic              mack_q, oe_q, start_q;
  logic [1:0]        chan_q;
  logic [DATA_W-1:0] adc_q;
  logic [1:0]        next_idx, cont_ch, first_ch;
  logic [7:0]        tx_first, tx_next;
  logic              rx_auto;

  // decision point of the command byte
  assign addr_done = (st == S_ADDR) && ev_fall && (bitcnt == 4'd8);
  assign addr_ok   = cmd_valid(rx_sh, NCH) && !busy;
  assign rx_auto   = !rx_sh[3] && (rx_sh[2:1] == 2'b11);
  assign first_ch  = rx_auto ? 2'd0 : rx_sh[2:1];

  assign next_idx  = cmd_lim ? byte_idx + 2'd1 : {1'b0, ~byte_idx[0]};
  assign cont_ch   = cmd_auto ? next_ch(cur_ch, NCH) : cur_ch;
  assign tx_first  = sel_byte(cmd_lim, 2'd0, cmd_lim ? cmd_ch : cur_ch, adc_q, rd_lower, rd_upper);
  assign tx_next   = sel_byte(cmd_lim, next_idx, cmd_lim ? cmd_ch : cur_ch, adc_q, rd_lower, rd_upper);

  assign wr_commit = ev_stop && (wcnt == 2'd2) && cmd_lim && !cmd_rd;
  assign wr_ch     = cmd_ch;
  assign wr_upper  = hdr_q[3];
  assign wr_val    = {hdr_q[2], hdr_q[1:0], lo_byte};

  assign sda_oe    = oe_q;
  assign adc_start = start_q;
  assign adc_chan  = chan_q;
  assign in_idle   = (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        adc_q <= '0;
    else if (adc_done) adc_q <= adc_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  bitcnt <= '0;  rx_sh <= '0;  tx_sh <= '0;  lo_byte <= '0;
      hdr_q <= '0;   cmd_lim <= 1'b0;  cmd_rd <= 1'b0;  cmd_auto <= 1'b0;
      cmd_ch <= '0;  cur_ch <= '0;  byte_idx <= '0;  wcnt <= '0;
      mack_q <= 1'b0;  oe_q <= 1'b0;  start_q <= 1'b0;  chan_q <= '0;
    end else begin
      start_q <= 1'b0;
      if (ev_start) begin
        st <= S_ADDR;  bitcnt <= '0;  oe_q <= 1'b0;  wcnt <= '0;
      end else if (ev_stop) begin
        st <= S_IDLE;  oe_q <= 1'b0;  wcnt <= '0;
      end else begin
        unique case (st)
          S_ADDR: begin
            if (ev_rise && bitcnt < 4'd8) begin
              rx_sh  <= {rx_sh[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end
            if (addr_done) begin
              if (addr_ok) begin
                st       <= S_ACKA;
                oe_q     <= 1'b1;
                cmd_lim  <= rx_sh[3];
                cmd_ch   <= rx_sh[2:1];
                cmd_rd   <= rx_sh[0];
                cmd_auto <= rx_auto;
                byte_idx <= '0;
                if (!rx_sh[3]) begin
                  cur_ch  <= first_ch;
                  chan_q  <= first_ch;
                  start_q <= 1'b1;
                end
              end else begin
                st <= S_SKIP;
              end
            end
          end
          S_ACKA: begin
            if (ev_fall) begin
              bitcnt <= '0;
              if (cmd_rd) begin
                tx_sh <= tx_first;
                oe_q  <= ~tx_first[7];
                st    <= S_TX;
              end else begin
                oe_q  <= 1'b0;
                st    <= S_RX;
              end
            end
          end
          S_RX: begin
            if (ev_rise && bitcnt < 4'd8) begin
              rx_sh  <= {rx_sh[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end
            if (ev_fall && bitcnt == 4'd8) begin
              if (wcnt < 2'd2) begin
                if (wcnt == 2'd0) hdr_q   <= rx_sh[3:0];
                else              lo_byte <= rx_sh;
                wcnt <= wcnt + 2'd1;
                oe_q <= 1'b1;
                st   <= S_ACKW;
              end else begin
                st <= S_SKIP;
              end
            end
          end
          S_ACKW: begin
            if (ev_fall) begin
              oe_q   <= 1'b0;
              bitcnt <= '0;
              st     <= S_RX;
            end
          end
          S_TX: begin
            if (ev_fall) begin
              if (bitcnt < 4'd7) begin
                tx_sh  <= {tx_sh[6:0], 1'b0};
                oe_q   <= ~tx_sh[6];
                bitcnt <= bitcnt + 4'd1;
              end else begin
                oe_q <= 1'b0;
                st   <= S_MACK;
              end
            end
          end
          S_MACK: begin
            if (ev_rise) begin
              mack_q <= ~sda_s;
              if (!sda_s && !cmd_lim && byte_idx[0]) begin
                cur_ch  <= cont_ch;
                chan_q  <= cont_ch;
                start_q <= 1'b1;
              end
            end
            if (ev_fall) begin
              if (mack_q) begin
                byte_idx <= next_idx;
                tx_sh    <= tx_next;
                oe_q     <= ~tx_next[7];
                bitcnt   <= '0;
                st       <= S_TX;
              end else begin
                st <= S_SKIP;
              end
            end
          end
          S_SKIP: oe_q <= 1'b0;
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/adcs_cmd_engine.sv
module adcs_cmd_engine
  import adcs_pkg::*;
#(
  parameter int NCH         = 3,
  parameter int WR_CYCLES   = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              adc_start,
  output logic [1:0]        adc_chan,
  input  logic              adc_done,
  input  logic [DATA_W-1:0] adc_data
);
  logic scl_s, sda_s, ev_rise, ev_fall, ev_start, ev_stop;
  logic busy, wr_commit, wr_upper, addr_done, addr_ok, in_idle;
  logic [1:0]       wr_ch;
  logic [LIM_W-1:0] wr_val, rd_lower, rd_upper;

  adcs_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .ev_rise(ev_rise), .ev_fall(ev_fall),
    .ev_start(ev_start), .ev_stop(ev_stop)
  );

  adcs_link #(.NCH(NCH)) u_link (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .ev_rise(ev_rise), .ev_fall(ev_fall),
    .ev_start(ev_start), .ev_stop(ev_stop), .sda_oe(sda_oe),
    .adc_start(adc_start), .adc_chan(adc_chan), .adc_done(adc_done), .adc_data(adc_data),
    .busy(busy), .wr_commit(wr_commit), .wr_ch(wr_ch), .wr_upper(wr_upper),
    .wr_val(wr_val), .rd_lower(rd_lower), .rd_upper(rd_upper),
    .addr_done(addr_done), .addr_ok(addr_ok), .in_idle(in_idle)
  );

  adcs_limit_file #(.NCH(NCH), .WR_CYCLES(WR_CYCLES)) u_lim (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_commit), .wr_ch(wr_ch), .wr_upper(wr_upper),
    .wr_val(wr_val), .rd_ch(wr_ch), .rd_lower(rd_lower), .rd_upper(rd_upper), .busy(busy)
  );
endmodule

// File: rtl/adcs_cmd_engine_chk.sv
module adcs_cmd_engine_chk #(
  parameter int NCH = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_oe,
  input logic       adc_start,
  input logic [1:0] adc_chan,
  input logic       busy,
  input logic       wr_commit,
  input logic       addr_done,
  input logic       in_idle
);
  a_r10_drive_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  a_r10_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_oe);

  a_r11_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  a_r11_chan_range: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> (int'(adc_chan) < NCH));

  a_r8_busy_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_commit));

  a_r8_nack_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && busy) |=> !sda_oe);
endmodule

bind adcs_cmd_engine adcs_cmd_engine_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe), .adc_start(adc_start),
  .adc_chan(adc_chan), .busy(busy), .wr_commit(wr_commit), .addr_done(addr_done),
  .in_idle(in_idle)
);

// File: tb/sim_adcs_cmd_engine.sv
`timescale 1ns/1ps
module sim_adcs_cmd_engine;
  localparam int NCH = 3;
  localparam int WRC = 2000;
  localparam int HP  = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, adc_start, adc_done = 1'b0;
  logic [1:0] adc_chan;
  logic [9:0] adc_data = '0;
  wire  sda_line = sda_m & ~sda_oe;

  int checks = 0, errors = 0, conv_n = 0;
  bit finished = 0;
  logic [1:0] chan_log [64];

  always #2.5 clk = ~clk;

  adcs_cmd_engine #(.NCH(NCH), .WR_CYCLES(WRC)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .adc_start(adc_start), .adc_chan(adc_chan), .adc_done(adc_done), .adc_data(adc_data)
  );

  function automatic logic [9:0] adc_val(input int n, input logic [1:0] ch);
    return 10'((n * 71 + int'(ch) * 193 + 5) % 1024);
  endfunction

  // converter model: answers three clocks after a start
  initial begin
    forever begin
      @(negedge clk);
      if (adc_start) begin
        chan_log[conv_n % 64] = adc_chan;
        adc_data = adc_val(conv_n, adc_chan);
        conv_n++;
        repeat (3) @(negedge clk);
        adc_done = 1'b1;
        @(negedge clk);
        adc_done = 1'b0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_bit(input logic v, output logic s);
    sda_m = v;
    wait_clk(HP);
    scl_m = 1'b1;
    wait_clk(HP / 2);
    s = sda_line;
    wait_clk(HP / 2);
    scl_m = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1;  wait_clk(HP);
    scl_m = 1'b1;  wait_clk(HP);
    sda_m = 1'b0;  wait_clk(HP);
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0;  wait_clk(HP);
    scl_m = 1'b1;  wait_clk(HP);
    sda_m = 1'b1;  wait_clk(HP);
  endtask

  task automatic tx_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) do_bit(b[i], s);
    do_bit(1'b1, s);
    acked = ~s;
  endtask

  task automatic rx_byte(input logic give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      do_bit(1'b1, s);
      b[i] = s;
    end
    do_bit(~give_ack, s);
  endtask

  function automatic logic [7:0] exp_lhdr(input logic [1:0] ch, input logic up, input logic [10:0] v);
    return {1'b1, ch, 1'b0, up, v[10], v[9], v[8]};
  endfunction

  task automatic t_reset();
    int starts;
    starts = conv_n;
    wait_clk(60);
    chk("R1 sda released after reset", 32'(sda_oe), 0);
    chk("R1 no start while idle", 32'(conv_n - starts), 0);
  endtask

  task automatic t_bad_type();
    logic a;
    logic [7:0] b;
    bus_start();
    tx_byte(8'h52, a);
    chk("R2 wrong type not acknowledged", 32'(a), 0);
    rx_byte(1'b0, b);
    chk("R2 line stays released after wrong type", 32'(b), 32'hFF);
    bus_stop();
  endtask

  task automatic t_conv(input string tag, input logic [1:0] cmd_ch, input int n, input bit autoinc);
    logic a;
    logic [7:0] h, l;
    int base;
    logic [1:0] ch;
    logic [9:0] v;
    base = conv_n;
    bus_start();
    tx_byte({4'b1001, 1'b0, cmd_ch, 1'b1}, a);
    chk({tag, " command acknowledged"}, 32'(a), 1);
    for (int k = 0; k < n; k++) begin
      ch = autoinc ? 2'(k % NCH) : cmd_ch;
      v  = adc_val(base + k, ch);
      rx_byte(1'b1, h);
      rx_byte(k < n - 1, l);
      chk({tag, " header byte"}, 32'(h), 32'({4'b0000, ch, v[9:8]}));
      chk({tag, " low byte"}, 32'(l), 32'(v[7:0]));
      chk({tag, " converter channel"}, 32'(chan_log[(base + k) % 64]), 32'(ch));
    end
    bus_stop();
    wait_clk(200);
    chk({tag, " start count"}, 32'(conv_n - base), 32'(n));
  endtask

  task automatic t_bad_cmds();
    logic a;
    int base;
    base = conv_n;
    bus_start();
    tx_byte(8'h92, a);
    chk("R9 monitor request not acknowledged", 32'(a), 0);
    bus_stop();
    bus_start();
    tx_byte(8'h9F, a);
    chk("R9 limit channel 3 not acknowledged", 32'(a), 0);
    bus_stop();
    chk("R9 no conversion from rejected commands", 32'(conv_n - base), 0);
  endtask

  task automatic lim_write(input logic [1:0] ch, input logic up, input logic [10:0] v,
                           input bit commit, output logic ok);
    logic a0, a1, a2;
    bus_start();
    tx_byte({4'b1001, 1'b1, ch, 1'b0}, a0);
    tx_byte({4'b0000, up, v[10], v[9:8]}, a1);
    tx_byte(v[7:0], a2);
    ok = a0 & a1 & a2;
    if (commit) bus_stop();
  endtask

  task automatic lim_read(input string tag, input logic [1:0] ch, input logic [10:0] lo,
                          input logic [10:0] hi);
    logic a;
    logic [7:0] b0, b1, b2, b3;
    bus_start();
    tx_byte({4'b1001, 1'b1, ch, 1'b1}, a);
    chk({tag, " read command acknowledged"}, 32'(a), 1);
    rx_byte(1'b1, b0);
    rx_byte(1'b1, b1);
    rx_byte(1'b1, b2);
    rx_byte(1'b0, b3);
    bus_stop();
    chk({tag, " lower header"}, 32'(b0), 32'(exp_lhdr(ch, 1'b0, lo)));
    chk({tag, " lower low byte"}, 32'(b1), 32'(lo[7:0]));
    chk({tag, " upper header"}, 32'(b2), 32'(exp_lhdr(ch, 1'b1, hi)));
    chk({tag, " upper low byte"}, 32'(b3), 32'(hi[7:0]));
  endtask

  task automatic t_limits();
    logic ok, a;
    lim_read("R7 reset values", 2'd1, 11'd0, 11'd0);
    lim_write(2'd1, 1'b0, 11'h599, 1'b1, ok);
    chk("R6 write bytes acknowledged", 32'(ok), 1);
    bus_start();
    tx_byte(8'h93, a);
    chk("R8 address refused while write busy", 32'(a), 0);
    bus_stop();
    wait_clk(WRC + 100);
    lim_read("R7 R6 after lower write", 2'd1, 11'h599, 11'd0);
    // repeated START before STOP must discard the pending value
    lim_write(2'd1, 1'b1, 11'h266, 1'b0, ok);
    bus_start();
    tx_byte(8'h00, a);
    bus_stop();
    lim_read("R6 discard on repeated start", 2'd1, 11'h599, 11'd0);
    lim_write(2'd1, 1'b1, 11'h266, 1'b1, ok);
    wait_clk(WRC + 100);
    lim_read("R7 R8 after upper write", 2'd1, 11'h599, 11'h266);
    lim_read("R7 other channel untouched", 2'd2, 11'd0, 11'd0);
  endtask

  initial begin
    wait_clk(10);
    rst_n = 1'b1;
    t_reset();
    t_bad_type();
    t_conv("R3 single ch1", 2'd1, 1, 1'b0);
    t_conv("R4 continuous ch2", 2'd2, 3, 1'b0);
    t_conv("R5 auto increment", 2'd3, 4, 1'b1);
    t_bad_cmds();
    t_limits();
    t_conv("R3 single ch0", 2'd0, 1, 1'b0);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule